// File: doc/BRIEF.md
# Nonvolatile SRAM store/recall sequencer

This controller sits beside a battery-free nonvolatile SRAM. It watches a digital flag that reports whether the supply is above the switch threshold, and a hardware store request. It records whether the SRAM has been written since the last nonvolatile transfer. When the supply comes up, it runs a timed recall. When the supply is lost, or a hardware store is requested, it runs a timed store, but only if the SRAM holds unsaved writes.

The controller gates the SRAM read and write enables. Access continues for a short grace window after a store is triggered, so that a cycle already in flight can finish. The controller also drives a handshake pin through separate level and drive-enable outputs. The pin is low while a store is in progress. After a store, it is driven high for a fixed time. While the supply is low it is left to a weak pull-up. The nonvolatile array itself is modelled only as start pulses and fixed waits. All durations are parameters counted in clock cycles.

Top module: `nvs_seq`

## Requirements
- R1: During reset and directly after it, `phase` is 0 (off), `busy` is 1, `hsb_oe` is 0, and both SRAM enables are 0 whatever the requests.
- R2: When `supply_ok` is first sampled high in the off phase, `recall_start` pulses for one cycle in the next cycle and `phase` becomes 1 (recall). Phase 1 lasts exactly RECALL_CYC cycles, after which `phase` is 2 (ready). If the supply drops during a recall, the phase returns to 0.
- R3: An accepted write sets an internal dirty flag from the next cycle onward. A store completion or a recall completion clears it. A write and a hardware request in the same cycle with the flag clear start no store, but a request one cycle later does.
- R4: With the dirty flag clear, loss of supply in phase 2 goes straight to phase 0, and a hardware store request leaves phase 2 unchanged. In neither case does `store_start` pulse.
- R5: A store trigger (supply loss or request with the flag set) enters phase 3 (grace) for GRACE_CYC cycles. In those cycles, reads and writes still pass. `store_start` then pulses in the first cycle of phase 4 (store).
- R6: Phase 4 lasts STORE_CYC cycles. Through phases 3 and 4, `hsb_oe` is 1 and `hsb_o` is 0.
- R7: After the store, phase 5 (release) drives `hsb_o`=1 with `hsb_oe`=1 for HIGH_CYC cycles. Then, if the supply is low, the phase goes to 0 with `hsb_oe`=0. If the supply is up and did not drop, the phase returns to 2.
- R8: SRAM enables are 0 in phases 0, 1, 4 and 5, and in phase 2 whenever `supply_ok` is low. In phase 2 with the supply up, and in phase 3, each enable follows its request.
- R9: `hsb_oe` is 0 in phase 0. In phases 1 and 2 it becomes 1 exactly ACT_CYC cycles after `supply_ok` is first sampled high.
- R10: A hardware store request during a store or a recall is ignored: the running phase continues with its timing unchanged.
- R11: If the supply returns while a power-loss store is running, the store and the release finish. A recall then follows (with a `recall_start` pulse) before phase 2 resumes.
- R12: `busy` is 0 exactly when `phase` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply is above the switch threshold |
| hw_store_req | input | 1 | Hardware store request |
| rd_req | input | 1 | SRAM read request |
| wr_req | input | 1 | SRAM write request |
| sram_rd_en | output | 1 | Gated read enable to the SRAM |
| sram_wr_en | output | 1 | Gated write enable to the SRAM |
| recall_start | output | 1 | One-cycle pulse at the start of a recall |
| store_start | output | 1 | One-cycle pulse at the start of a store |
| hsb_o | output | 1 | Handshake pin level |
| hsb_oe | output | 1 | Handshake pin drive enable |
| busy | output | 1 | Not in the ready phase |
| phase | output | 3 | Current phase: 0 off, 1 recall, 2 ready, 3 grace, 4 store, 5 release |

## Verification
Two functions can land in the same cycle: a write that makes the SRAM dirty, and the store decision that reads the dirty flag. The bench issues the first write of a session together with a hardware store request. It expects the write to pass while the phase stays ready, and it expects a request repeated one cycle later to open the grace window. A second collision is provoked by raising the supply again in the middle of a power-loss store. The bench then checks that the store and the release run to their full lengths, and that a fresh recall pulse appears before access resumes.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_RECALL  = 3'd1,
        PH_READY   = 3'd2,
        PH_GRACE   = 3'd3,
        PH_STORE   = 3'd4,
        PH_RELEASE = 3'd5
    } phase_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic access_allowed(phase_e ph, logic sup);
        return (ph == PH_GRACE) || ((ph == PH_READY) && sup);
    endfunction

endpackage

// File: rtl/nvs_dirty.sv
module nvs_dirty (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic dirty_o
);
    always_ff @(posedge clk) begin
        if (rst)        dirty_o <= 1'b0;
        else if (clr_i) dirty_o <= 1'b0;
        else if (set_i) dirty_o <= 1'b1;
    end

    p_clear_r3: assert property (@(posedge clk) disable iff (rst) clr_i |=> !dirty_o);
    p_set_r3:   assert property (@(posedge clk) disable iff (rst) (set_i && !clr_i) |=> dirty_o);
endmodule

// File: rtl/nvs_hsb.sv
module nvs_hsb
    import nvs_pkg::*;
#(
    parameter int unsigned ACT_CYC = 1250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   supply_ok,
    input  phase_e phase_i,
    output pin_t   pin_o
);
    localparam int unsigned AW = $clog2(ACT_CYC + 1);
    localparam logic [AW-1:0] ACT_LIM = AW'(ACT_CYC);

    logic [AW-1:0] act_q;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) act_q <= '0;
        else if (act_q != ACT_LIM) act_q <= act_q + 1'b1;
    end

    assign armed = (act_q == ACT_LIM);

    always_comb begin
        pin_o = '{drive: 1'b0, level: 1'b1};
        case (phase_i)
            PH_RECALL, PH_READY: pin_o = '{drive: armed, level: 1'b1};
            PH_GRACE, PH_STORE:  pin_o = '{drive: 1'b1,  level: 1'b0};
            PH_RELEASE:          pin_o = '{drive: 1'b1,  level: 1'b1};
            default:             pin_o = '{drive: 1'b0,  level: 1'b1};
        endcase
    end

    p_arm_needs_supply_r9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !armed);
endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int unsigned RECALL_CYC = 5000000,
    parameter int unsigned STORE_CYC  = 2000000,
    parameter int unsigned GRACE_CYC  = 7,
    parameter int unsigned HIGH_CYC   = 125
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   supply_ok,
    input  logic   hw_store_req,
    input  logic   dirty,
    output phase_e phase_o,
    output logic   recall_start,
    output logic   store_start,
    output logic   nv_done
);
    localparam int unsigned MAXD = max3(max3(RECALL_CYC, STORE_CYC, GRACE_CYC), HIGH_CYC, 1);
    localparam int unsigned CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] LD_RC = CW'(RECALL_CYC - 1);
    localparam logic [CW-1:0] LD_ST = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] LD_GR = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] LD_HI = CW'(HIGH_CYC - 1);

    phase_e        state, nxt;
    logic [CW-1:0] cnt, cnt_n;
    logic          lost, lost_n;
    logic          expired;

    assign expired = (cnt == '0);
    assign phase_o = state;

    always_comb begin
        nxt     = state;
        cnt_n   = expired ? '0 : cnt - 1'b1;
        lost_n  = lost;
        nv_done = 1'b0;
        case (state)
            PH_OFF: begin
                if (supply_ok) begin
                    nxt    = PH_RECALL;
                    cnt_n  = LD_RC;
                    lost_n = 1'b0;
                end
            end
            PH_RECALL: begin
                if (!supply_ok) begin
                    nxt = PH_OFF;
                end else if (expired) begin
                    nxt     = PH_READY;
                    nv_done = 1'b1;
                end
            end
            PH_READY: begin
                if (!supply_ok) begin
                    if (dirty) begin
                        nxt    = PH_GRACE;
                        cnt_n  = LD_GR;
                        lost_n = 1'b1;
                    end else begin
                        nxt = PH_OFF;
                    end
                end else if (hw_store_req && dirty) begin
                    nxt   = PH_GRACE;
                    cnt_n = LD_GR;
                end
            end
            PH_GRACE: begin
                if (!supply_ok) lost_n = 1'b1;
                if (expired) begin
                    nxt   = PH_STORE;
                    cnt_n = LD_ST;
                end
            end
            PH_STORE: begin
                if (!supply_ok) lost_n = 1'b1;
                if (expired) begin
                    nxt     = PH_RELEASE;
                    cnt_n   = LD_HI;
                    nv_done = 1'b1;
                end
            end
            PH_RELEASE: begin
                if (!supply_ok) lost_n = 1'b1;
                if (expired) begin
                    if (!supply_ok) begin
                        nxt = PH_OFF;
                    end else if (lost) begin
                        nxt    = PH_RECALL;
                        cnt_n  = LD_RC;
                        lost_n = 1'b0;
                    end else begin
                        nxt = PH_READY;
                    end
                end
            end
            default: nxt = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= PH_OFF;
            cnt          <= '0;
            lost         <= 1'b0;
            recall_start <= 1'b0;
            store_start  <= 1'b0;
        end else begin
            state        <= nxt;
            cnt          <= cnt_n;
            lost         <= lost_n;
            recall_start <= (nxt == PH_RECALL) && (state != PH_RECALL);
            store_start  <= (nxt == PH_STORE) && (state != PH_STORE);
        end
    end

    p_recall_abort_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RECALL && !supply_ok) |=> state == PH_OFF);
    p_clean_no_store_r4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_READY && !dirty && !supply_ok) |=> state == PH_OFF);
    p_start_after_grace_r5: assert property (@(posedge clk) disable iff (rst)
        store_start |-> $past(state) == PH_GRACE);
    p_hw_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_STORE && hw_store_req) |=> (state == PH_STORE || state == PH_RELEASE));
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int unsigned RECALL_CYC = 5000000,
    parameter int unsigned STORE_CYC  = 2000000,
    parameter int unsigned GRACE_CYC  = 7,
    parameter int unsigned HIGH_CYC   = 125,
    parameter int unsigned ACT_CYC    = 1250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       hw_store_req,
    input  logic       rd_req,
    input  logic       wr_req,
    output logic       sram_rd_en,
    output logic       sram_wr_en,
    output logic       recall_start,
    output logic       store_start,
    output logic       hsb_o,
    output logic       hsb_oe,
    output logic       busy,
    output logic [2:0] phase
);
    phase_e ph;
    pin_t   pin;
    logic   dirty, nv_done, access_ok;

    nvs_fsm #(
        .RECALL_CYC(RECALL_CYC),
        .STORE_CYC (STORE_CYC),
        .GRACE_CYC (GRACE_CYC),
        .HIGH_CYC  (HIGH_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .hw_store_req(hw_store_req),
        .dirty       (dirty),
        .phase_o     (ph),
        .recall_start(recall_start),
        .store_start (store_start),
        .nv_done     (nv_done)
    );

    nvs_dirty u_dirty (
        .clk    (clk),
        .rst    (rst),
        .set_i  (sram_wr_en),
        .clr_i  (nv_done),
        .dirty_o(dirty)
    );

    nvs_hsb #(.ACT_CYC(ACT_CYC)) u_hsb (
        .clk      (clk),
        .rst      (rst),
        .supply_ok(supply_ok),
        .phase_i  (ph),
        .pin_o    (pin)
    );

    assign access_ok  = access_allowed(ph, supply_ok);
    assign sram_rd_en = rd_req & access_ok;
    assign sram_wr_en = wr_req & access_ok;
    assign hsb_o      = pin.level;
    assign hsb_oe     = pin.drive;
    assign busy       = (ph != PH_READY);
    assign phase      = ph;

    p_store_pin_low_r6: assert property (@(posedge clk) disable iff (rst)
        store_start |-> (hsb_oe && !hsb_o));
    p_off_released_r9: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_OFF) |-> !hsb_oe);
    p_no_write_in_store_r8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STORE || ph == PH_RECALL) |-> !(sram_wr_en || sram_rd_en));
endmodule

// File: tb/nvs_seq_test.sv
module nvs_seq_test;
    localparam int RC = 20;
    localparam int SC = 12;
    localparam int GC = 3;
    localparam int HC = 4;
    localparam int AC = 5;

    localparam int F_PH = 0, F_RDEN = 1, F_WREN = 2, F_OE = 3, F_O = 4, F_RS = 5, F_SS = 6, F_BUSY = 7;

    typedef struct {
        int    cyc;
        int    fld;
        int    val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst, supply_ok, hw_store_req, rd_req, wr_req;
    logic sram_rd_en, sram_wr_en, recall_start, store_start, hsb_o, hsb_oe, busy;
    logic [2:0] phase;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvs_seq #(
        .RECALL_CYC(RC), .STORE_CYC(SC), .GRACE_CYC(GC), .HIGH_CYC(HC), .ACT_CYC(AC)
    ) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .hw_store_req(hw_store_req),
        .rd_req(rd_req), .wr_req(wr_req), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en),
        .recall_start(recall_start), .store_start(store_start), .hsb_o(hsb_o),
        .hsb_oe(hsb_oe), .busy(busy), .phase(phase)
    );

    function automatic int actual(int f);
        case (f)
            F_PH:    return int'(phase);
            F_RDEN:  return int'(sram_rd_en);
            F_WREN:  return int'(sram_wr_en);
            F_OE:    return int'(hsb_oe);
            F_O:     return int'(hsb_o);
            F_RS:    return int'(recall_start);
            F_SS:    return int'(store_start);
            default: return int'(busy);
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int d, int f, int v, string r);
        exp_q.push_back('{cyc + d, f, v, r});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc == cyc) begin
                int a;
                a = actual(exp_q[i].fld);
                checks++;
                if (a != exp_q[i].val) begin
                    errors++;
                    $display("FAIL %s field=%0d cycle=%0d actual=%0d expected=%0d",
                             exp_q[i].req, exp_q[i].fld, cyc, a, exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    // R2, R8, R9, R12: power-up recall; rd_req must be 1
    task automatic power_up();
        supply_ok = 1'b1;
        expect_at(1, F_PH, 1, "R2");
        expect_at(1, F_RS, 1, "R2");
        expect_at(2, F_RS, 0, "R2");
        expect_at(AC - 1, F_OE, 0, "R9");
        expect_at(AC, F_OE, 1, "R9");
        expect_at(RC, F_PH, 1, "R2");
        expect_at(RC, F_RDEN, 0, "R8");
        expect_at(RC, F_BUSY, 1, "R12");
        expect_at(RC + 1, F_PH, 2, "R2");
        expect_at(RC + 1, F_RDEN, 1, "R8");
        expect_at(RC + 1, F_BUSY, 0, "R12");
        repeat (RC + 2) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; supply_ok = 1'b0; hw_store_req = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
        repeat (3) tick();
        rd_req = 1'b1;
        expect_at(0, F_PH, 0, "R1");
        expect_at(0, F_OE, 0, "R1");
        expect_at(0, F_BUSY, 1, "R1");
        expect_at(0, F_RDEN, 0, "R1");
        tick();
        rst = 1'b0;
        tick();
        expect_at(0, F_RDEN, 0, "R8");
        expect_at(0, F_PH, 0, "R1");
        tick();

        power_up();

        // R4: hardware request while clean is ignored
        hw_store_req = 1'b1;
        expect_at(1, F_PH, 2, "R4");
        expect_at(1, F_SS, 0, "R4");
        tick();
        hw_store_req = 1'b0;
        tick();
        expect_at(0, F_PH, 2, "R4");
        tick();

        // R3: first write and request in the same cycle start nothing
        wr_req = 1'b1; hw_store_req = 1'b1;
        expect_at(0, F_WREN, 1, "R3");
        expect_at(1, F_PH, 2, "R3");
        tick();
        // request one cycle later starts the store (R3, R5, R6, R7)
        expect_at(1, F_PH, 3, "R5");
        expect_at(1, F_OE, 1, "R6");
        expect_at(1, F_O, 0, "R6");
        expect_at(GC, F_WREN, 1, "R5");
        expect_at(GC + 1, F_WREN, 0, "R8");
        expect_at(GC + 1, F_SS, 1, "R5");
        expect_at(GC + 1, F_PH, 4, "R6");
        expect_at(GC + SC, F_PH, 4, "R6");
        expect_at(GC + SC, F_O, 0, "R6");
        expect_at(GC + SC + 1, F_PH, 5, "R7");
        expect_at(GC + SC + 1, F_O, 1, "R7");
        expect_at(GC + SC + 1, F_OE, 1, "R7");
        expect_at(GC + SC + HC, F_PH, 5, "R7");
        expect_at(GC + SC + HC + 1, F_PH, 2, "R7");
        expect_at(GC + SC + HC + 1, F_OE, 1, "R9");
        expect_at(GC + SC + HC + 1, F_BUSY, 0, "R12");
        tick();
        hw_store_req = 1'b0;
        repeat (GC) tick();
        wr_req = 1'b0;
        tick();
        // R10: request during store is ignored
        hw_store_req = 1'b1;
        expect_at(1, F_PH, 4, "R10");
        expect_at(1, F_SS, 0, "R10");
        tick();
        hw_store_req = 1'b0;
        repeat (SC + HC - 1) tick();
        // R3: flag cleared by store completion, request ignored
        hw_store_req = 1'b1;
        expect_at(0, F_PH, 2, "R3");
        expect_at(1, F_PH, 2, "R3");
        tick();
        hw_store_req = 1'b0;
        tick();

        // R4: clean power loss goes straight to off
        supply_ok = 1'b0;
        expect_at(0, F_RDEN, 0, "R8");
        expect_at(1, F_PH, 0, "R4");
        expect_at(1, F_OE, 0, "R9");
        expect_at(1, F_SS, 0, "R4");
        expect_at(2, F_PH, 0, "R4");
        repeat (3) tick();

        power_up();

        // R11: power-loss store, supply returns mid-store
        wr_req = 1'b1;
        tick();
        wr_req = 1'b0;
        supply_ok = 1'b0;
        expect_at(0, F_RDEN, 0, "R8");
        expect_at(1, F_PH, 3, "R5");
        expect_at(1, F_RDEN, 1, "R5");
        expect_at(GC, F_RDEN, 1, "R5");
        expect_at(GC + 1, F_RDEN, 0, "R8");
        expect_at(GC + 1, F_SS, 1, "R5");
        expect_at(GC + SC, F_PH, 4, "R11");
        expect_at(GC + SC + HC, F_PH, 5, "R11");
        expect_at(GC + SC + HC + 1, F_PH, 1, "R11");
        expect_at(GC + SC + HC + 1, F_RS, 1, "R11");
        expect_at(GC + SC + HC + RC, F_PH, 1, "R11");
        expect_at(GC + SC + HC + RC + 1, F_PH, 2, "R11");
        expect_at(GC + SC + HC + RC + 1, F_RDEN, 1, "R11");
        repeat (GC + 3) tick();
        supply_ok = 1'b1;
        repeat (SC + HC + RC + 1) tick();

        // R7: power-loss store with supply staying low releases the pin
        wr_req = 1'b1;
        tick();
        wr_req = 1'b0;
        supply_ok = 1'b0;
        expect_at(GC + SC + 1, F_RDEN, 0, "R8");
        expect_at(GC + SC + HC, F_OE, 1, "R7");
        expect_at(GC + SC + HC, F_O, 1, "R7");
        expect_at(GC + SC + HC + 1, F_OE, 0, "R7");
        expect_at(GC + SC + HC + 1, F_PH, 0, "R7");
        expect_at(GC + SC + HC + 1, F_BUSY, 1, "R12");
        repeat (GC + SC + HC + 4) tick();

        if (exp_q.size() != 0) begin
            errors += exp_q.size();
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule